// File: doc/BRIEF.md
# Shared Radix-2 SRT Divide / Square-Root Unit

This block is an iterative arithmetic unit that computes either the quotient of two unsigned fractions or the square root of one unsigned fraction. Both operations run on the same residual register, the same adder and the same digit selector. One result digit in {-1, 0, +1} is produced per clock. Each digit is folded at once into a pair of binary registers (the partial result and the partial result minus one unit in its last place). The final answer is therefore picked by a multiplexer on the sign of the last residual, and no correction addition is needed.

A request is presented on a valid/ready pair. The sender holds `in_valid` and the operands until a clock edge where `in_ready` is high. A request offered while `in_ready` is low is not stored and has no effect. Legal requests end with a one-cycle `done` pulse. The result output has no back-pressure: `result` holds its value until the next `done`. Illegal operands end the request with an error instead. The error stays raised, and the unit takes no new requests, until the error is acknowledged. All control is synchronous to `clk`, and latency in cycles grows with the operand width `W` (default 8).

Top module: `srt_divsqrt_unit`

## Requirements
- R1: With `in_op`=0 (divide), divisor `in_b` having its top bit set and dividend `in_a` < `in_b`, `result` equals floor(`in_a`·2^W / `in_b`).
- R2: With `in_op`=1 (square root) and at least one of the two top bits of `in_a` set, `result` equals floor(sqrt(`in_a`·2^W)).
- R3: `done` is high for exactly one cycle, W+1 clock edges after the edge that accepted the request, and `result` keeps that value until the next `done`.
- R4: `in_ready` is high only when the unit is idle with no error pending. A request offered while `in_ready` is low is dropped: it changes neither the running result nor the number of `done` pulses.
- R5: A divide with `in_b` = 0 raises `err_valid` with `err_code` = 2'b01 on the edge after acceptance, and gives no `done`. This takes precedence over R6.
- R6: A divide with a nonzero `in_b` whose top bit is clear, or with `in_a` >= `in_b`, and a square root with the two top bits of `in_a` both clear, raise `err_valid` with `err_code` = 2'b10 on the edge after acceptance, and give no `done`.
- R7: `err_valid` and `err_code` stay unchanged until an edge with `err_ack` high. After that edge `err_valid` is low, `err_code` is 2'b00 and `in_ready` is high.
- R8: After reset, `in_ready` is 1, and `done`, `err_valid`, `err_code` and `result` are 0.
- R9: Digits are chosen from the sign and the bits down to weight 1/2 of the doubled residual. In divide mode this keeps the magnitude of the residual no larger than the divisor on every step.
- R10: Operands are captured on the accepting edge. Later changes on `in_op`, `in_a` and `in_b` do not affect the running operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request offered |
| in_ready | output | 1 | Unit idle and able to accept |
| in_op | input | 1 | 0 = divide, 1 = square root |
| in_a | input | W | Dividend or radicand (fraction) |
| in_b | input | W | Divisor (fraction); ignored for square root |
| done | output | 1 | One-cycle pulse: `result` is valid |
| result | output | W | Quotient or root (fraction) |
| err_valid | output | 1 | Illegal operands, waiting for acknowledge |
| err_code | output | 2 | 00 none, 01 zero divisor, 10 operand out of range |
| err_ack | input | 1 | Clears a pending error |

## Verification
The residual-bound and converter-gap assertions assume that only operands passing the legality check ever start an iteration. They also assume that `in_op`, `in_a`, `in_b` and `err_ack` are known values whenever they are sampled. The bench drives every input from reset onward on the falling edge with defined values. It sends out-of-range operands only in the error cases, and there it checks that no iteration starts. While a request runs, the bench deliberately puts inverted garbage on the operand pins, so any assumption about their stability after acceptance would show up.

// File: rtl/srt_pkg.sv
package srt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_RUN  = 2'b01,
    ST_FIN  = 2'b10,
    ST_ERR  = 2'b11
  } srt_state_e;

  // signed digit in two's complement form
  typedef enum logic [1:0] {
    DIG_ZERO = 2'b00,
    DIG_POS  = 2'b01,
    DIG_NEG  = 2'b11
  } srt_digit_e;

  typedef enum logic [1:0] {
    ERR_NONE    = 2'b00,
    ERR_DIVZERO = 2'b01,
    ERR_RANGE   = 2'b10
  } srt_err_e;

  localparam logic OP_DIV  = 1'b0;
  localparam logic OP_SQRT = 1'b1;
endpackage

// File: rtl/srt_ctrl.sv
module srt_ctrl import srt_pkg::*; #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic         in_op,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  input  logic         err_ack,
  output logic         in_ready,
  output logic         load,
  output logic         step,
  output logic         finish,
  output logic         op_sqrt,
  output logic [W-1:0] weight,
  output logic         err_valid,
  output logic [1:0]   err_code
);
  localparam logic [W-1:0] W_TOP = {1'b1, {(W-1){1'b0}}};

  srt_state_e   state_q;
  srt_err_e     err_q;
  srt_err_e     chk_code;
  logic [W-1:0] weight_q;
  logic         op_q;
  logic         accept;

  // operand legality, zero divisor first
  always_comb begin
    chk_code = ERR_NONE;
    if (in_op == OP_DIV) begin
      if (in_b == '0)
        chk_code = ERR_DIVZERO;
      else if (!in_b[W-1] || (in_a >= in_b))
        chk_code = ERR_RANGE;
    end else if (in_a[W-1:W-2] == 2'b00) begin
      chk_code = ERR_RANGE;
    end
  end

  assign accept = in_valid && (state_q == ST_IDLE);
  assign load   = accept && (chk_code == ERR_NONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      err_q    <= ERR_NONE;
      weight_q <= '0;
      op_q     <= OP_DIV;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            if (chk_code != ERR_NONE) begin
              state_q <= ST_ERR;
              err_q   <= chk_code;
            end else begin
              state_q  <= ST_RUN;
              weight_q <= W_TOP;
              op_q     <= in_op;
            end
          end
        end
        ST_RUN: begin
          weight_q <= weight_q >> 1;
          if (weight_q[0]) state_q <= ST_FIN;
        end
        ST_FIN: state_q <= ST_IDLE;
        ST_ERR: begin
          if (err_ack) begin
            state_q <= ST_IDLE;
            err_q   <= ERR_NONE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign in_ready  = (state_q == ST_IDLE);
  assign step      = (state_q == ST_RUN);
  assign finish    = (state_q == ST_FIN);
  assign op_sqrt   = op_q;
  assign weight    = weight_q;
  assign err_valid = (state_q == ST_ERR);
  assign err_code  = err_q;

  // R7
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_valid && !err_ack) |=> (err_valid && $stable(err_code)));

  // R5
  divzero_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (in_op == OP_DIV) && (in_b == '0)) |=> (err_valid && (err_code == ERR_DIVZERO)));

  // R3
  weight_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> ($countones(weight_q) == 1));
endmodule

// File: rtl/srt_select.sv
module srt_select import srt_pkg::*; #(
  parameter int EW = 5
) (
  input  logic [EW-1:0] est,
  output srt_digit_e    digit
);
  // est = doubled residual truncated at weight 1/2 (signed)
  always_comb begin
    if (!est[EW-1])
      digit = DIG_POS;
    else if (&est)
      digit = DIG_ZERO;
    else
      digit = DIG_NEG;
  end
endmodule

// File: rtl/srt_otf.sv
module srt_otf import srt_pkg::*; #(
  parameter int W  = 8,
  parameter int QW = W + 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic                 step,
  input  srt_digit_e           digit,
  input  logic [W-1:0]         weight,
  output logic signed [QW-1:0] q,
  output logic signed [QW-1:0] qm
);
  localparam logic signed [QW-1:0] QM_INIT = {2'b11, {W{1'b0}}};

  logic signed [QW-1:0] wbit;
  assign wbit = {{(QW-W){1'b0}}, weight};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q  <= '0;
      qm <= QM_INIT;
    end else if (load) begin
      q  <= '0;
      qm <= QM_INIT;
    end else if (step) begin
      case (digit)
        DIG_POS: begin
          q  <= q | wbit;
          qm <= q;
        end
        DIG_NEG: begin
          q  <= qm | wbit;
        end
        default: begin
          qm <= qm | wbit;
        end
      endcase
    end
  end

  // R1
  otf_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (weight != '0) |-> ((q - qm) == (wbit <<< 1)));
endmodule

// File: rtl/srt_residual.sv
module srt_residual import srt_pkg::*; #(
  parameter int W  = 8,
  parameter int QW = W + 2,
  parameter int RW = W + 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic                 step,
  input  logic                 op_sqrt,
  input  logic [W-1:0]         in_a,
  input  logic [W-1:0]         in_b,
  input  logic signed [QW-1:0] q,
  input  logic signed [QW-1:0] qm,
  input  logic [W-1:0]         weight,
  output srt_digit_e           digit,
  output logic                 rem_neg
);
  localparam int EW = RW - W + 1;
  localparam logic signed [RW-1:0] SQ_LIM = RW'(3) <<< W;

  logic signed [RW-1:0] r_q, t, b_x, w_x, q_x, qm_x, term, addend, r_next;
  logic [W-1:0]         b_q;
  logic                 cin;

  assign t    = r_q <<< 1;
  assign b_x  = {{(RW-W){1'b0}}, b_q};
  assign w_x  = {{(RW-W){1'b0}}, weight};
  assign q_x  = {{(RW-QW){q[QW-1]}}, q};
  assign qm_x = {{(RW-QW){qm[QW-1]}}, qm};

  srt_select #(.EW(EW)) u_sel (
    .est   (t[RW-1:W-1]),
    .digit (digit)
  );

  // term subtracted for +1 / added for -1
  always_comb begin
    if (!op_sqrt)
      term = b_x;
    else if (digit == DIG_NEG)
      term = (qm_x <<< 1) | (w_x <<< 1) | w_x;
    else
      term = (q_x <<< 1) | w_x;
    addend = (digit == DIG_NEG) ? term : ~term;
    cin    = (digit == DIG_POS);
    r_next = (digit == DIG_ZERO) ? t : (t + addend + {{(RW-1){1'b0}}, cin});
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r_q <= '0;
      b_q <= '0;
    end else if (load) begin
      r_q <= {{(RW-W){1'b0}}, in_a};
      b_q <= in_b;
    end else if (step) begin
      r_q <= r_next;
    end
  end

  assign rem_neg = r_q[RW-1];

  // R9
  div_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !op_sqrt) |-> ((r_q <= b_x) && (r_q >= -b_x)));

  // R2
  sqrt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && op_sqrt) |-> ((r_q < SQ_LIM) && (r_q > -SQ_LIM)));
endmodule

// File: rtl/srt_divsqrt_unit.sv
module srt_divsqrt_unit import srt_pkg::*; #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic         in_op,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  output logic         done,
  output logic [W-1:0] result,
  output logic         err_valid,
  output logic [1:0]   err_code,
  input  logic         err_ack
);
  localparam int QW = W + 2;
  localparam int RW = W + 4;

  logic                 load, step, finish, op_sqrt, rem_neg;
  logic [W-1:0]         weight;
  logic signed [QW-1:0] q, qm;
  srt_digit_e           digit;
  logic                 done_q;
  logic [W-1:0]         res_q;

  srt_ctrl #(.W(W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_op     (in_op),
    .in_a      (in_a),
    .in_b      (in_b),
    .err_ack   (err_ack),
    .in_ready  (in_ready),
    .load      (load),
    .step      (step),
    .finish    (finish),
    .op_sqrt   (op_sqrt),
    .weight    (weight),
    .err_valid (err_valid),
    .err_code  (err_code)
  );

  srt_residual #(.W(W), .QW(QW), .RW(RW)) u_res (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .step    (step),
    .op_sqrt (op_sqrt),
    .in_a    (in_a),
    .in_b    (in_b),
    .q       (q),
    .qm      (qm),
    .weight  (weight),
    .digit   (digit),
    .rem_neg (rem_neg)
  );

  srt_otf #(.W(W), .QW(QW)) u_otf (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (load),
    .step   (step),
    .digit  (digit),
    .weight (weight),
    .q      (q),
    .qm     (qm)
  );

  // pick Q or Q-1 by the sign of the last residual
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      res_q  <= '0;
    end else begin
      done_q <= finish;
      if (finish) res_q <= rem_neg ? qm[W-1:0] : q[W-1:0];
    end
  end

  assign done   = done_q;
  assign result = res_q;

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R5
  no_mix_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err_valid));

  // R4
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(!in_ready));
endmodule

// File: tb/srt_divsqrt_unit_test.sv
`timescale 1ns/1ps
module srt_divsqrt_unit_test;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_op = 1'b0;
  logic [W-1:0] in_a = '0;
  logic [W-1:0] in_b = '0;
  logic         err_ack = 1'b0;
  logic         in_ready, done, err_valid;
  logic [W-1:0] result;
  logic [1:0]   err_code;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  srt_divsqrt_unit #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_a(in_a), .in_b(in_b), .done(done), .result(result),
    .err_valid(err_valid), .err_code(err_code), .err_ack(err_ack)
  );

  // {op, a, b, expected code, expected result}
  localparam logic [26:0] VEC [0:16] = '{
    {1'b0, 8'h40, 8'h80, 2'd0, 8'h80},
    {1'b0, 8'h7F, 8'h80, 2'd0, 8'hFE},
    {1'b0, 8'hFE, 8'hFF, 2'd0, 8'hFE},
    {1'b0, 8'h00, 8'hC0, 2'd0, 8'h00},
    {1'b0, 8'h55, 8'hAA, 2'd0, 8'h80},
    {1'b0, 8'h01, 8'hFF, 2'd0, 8'h01},
    {1'b1, 8'h40, 8'h00, 2'd0, 8'h80},
    {1'b1, 8'hFF, 8'h00, 2'd0, 8'hFF},
    {1'b1, 8'h90, 8'h00, 2'd0, 8'hC0},
    {1'b1, 8'h41, 8'h00, 2'd0, 8'h80},
    {1'b1, 8'h64, 8'h00, 2'd0, 8'hA0},
    {1'b0, 8'h05, 8'h00, 2'd1, 8'h00},
    {1'b0, 8'h00, 8'h00, 2'd1, 8'h00},
    {1'b0, 8'h80, 8'h80, 2'd2, 8'h00},
    {1'b0, 8'h10, 8'h7F, 2'd2, 8'h00},
    {1'b1, 8'h3F, 8'h00, 2'd2, 8'h00},
    {1'b1, 8'h00, 8'h00, 2'd2, 8'h00}
  };

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int isqrt(input int v);
    int r = 0;
    while ((r + 1) * (r + 1) <= v) r++;
    return r;
  endfunction

  // drives one request; garbage on operands while busy (R10)
  task automatic run_op(input logic op, input logic [W-1:0] a, input logic [W-1:0] b,
                        input bit poke, output logic [W-1:0] res,
                        output logic [1:0] code, output int lat);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_a = a; in_b = b;
    @(posedge clk);
    @(negedge clk);
    lat = 0;
    in_op = ~op; in_a = ~a; in_b = ~b;
    in_valid = poke;
    code = err_code;
    if (err_valid) begin
      in_valid = 1'b0;
      res = result;
      return;
    end
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
      in_valid = poke && (lat < W);
    end
    in_valid = 1'b0;
    res = result;
  endtask

  task automatic ack_err();
    @(negedge clk);
    err_ack = 1'b1;
    @(posedge clk);
    @(negedge clk);
    err_ack = 1'b0;
    chk("R7 err_valid after ack", int'(err_valid), 0);
    chk("R7 err_code after ack", int'(err_code), 0);
    chk("R7 in_ready after ack", int'(in_ready), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL R3 watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [W-1:0] res;
    logic [1:0]   code;
    int           lat;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 reset state
    chk("R8 in_ready", int'(in_ready), 1);
    chk("R8 done", int'(done), 0);
    chk("R8 err_valid", int'(err_valid), 0);
    chk("R8 err_code", int'(err_code), 0);
    chk("R8 result", int'(result), 0);

    // table walk (R1, R2, R5, R6, R3, R10)
    for (int i = 0; i < 17; i++) begin
      logic       vop;
      logic [7:0] va, vb, vres;
      logic [1:0] vcode;
      {vop, va, vb, vcode, vres} = VEC[i];
      run_op(vop, va, vb, 1'b0, res, code, lat);
      if (vcode == 2'd1) begin
        chk("R5 code", int'(code), 1);
        chk("R5 err_valid", int'(err_valid), 1);
        ack_err();
      end else if (vcode == 2'd2) begin
        chk("R6 code", int'(code), 2);
        chk("R6 no done", int'(done), 0);
        ack_err();
      end else begin
        chk(vop ? "R2 table result" : "R1 table result", int'(res), int'(vres));
        chk("R3 latency", lat, W + 1);
        @(negedge clk);
        chk("R3 done single cycle", int'(done), 0);
      end
    end

    // R4: requests offered while busy are dropped
    run_op(1'b0, 8'h40, 8'h80, 1'b1, res, code, lat);
    chk("R4 result under busy requests", int'(res), 8'h80);
    chk("R4 latency under busy requests", lat, W + 1);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R4 no extra done", int'(done), 0);
      chk("R3 result held", int'(result), 8'h80);
      chk("R4 ready when idle", int'(in_ready), 1);
    end

    // R7: error pending blocks requests and holds code
    run_op(1'b0, 8'h20, 8'h00, 1'b0, res, code, lat);
    chk("R5 zero divisor code", int'(code), 1);
    @(negedge clk);
    in_valid = 1'b1; in_op = 1'b1; in_a = 8'h90; in_b = 8'h00;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R7 err held", int'(err_valid), 1);
      chk("R7 code held", int'(err_code), 1);
      chk("R4 not ready with error", int'(in_ready), 0);
      chk("R7 no done while pending", int'(done), 0);
    end
    in_valid = 1'b0;
    ack_err();
    @(negedge clk);
    chk("R4 request during error left no trace", int'(done), 0);

    // R2 sweep of every legal radicand
    for (int a = 64; a < 256; a++) begin
      run_op(1'b1, 8'(a), 8'h00, 1'b0, res, code, lat);
      chk("R2 sqrt sweep", int'(res), isqrt(a * 256));
    end

    // R1 / R9 sweep over every normalised divisor
    for (int b = 128; b < 256; b++) begin
      for (int a = 0; a < b; a += 5) begin
        run_op(1'b0, 8'(a), 8'(b), 1'b0, res, code, lat);
        chk("R1 R9 divide sweep", int'(res), (a * 256) / b);
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule